// File: doc/BRIEF.md
# Multi-Core System Counter with Indexed Register Access

This block keeps one free-running 64-bit system count shared by a group of processor cores, and gives each core its own compare value and level interrupt. The count advances on ticks of a prescaler that divides the reference clock by 1, 2 or 4. A single global enable bit starts or holds counting for all cores at once. There is no per-core start control.

Software sees only two 32-bit bus locations. The index register is at byte offset 0x4 and the data window is at offset 0x0. Every internal register is reached in two steps: write its internal address to the index register, then read or write the data window. The internal register map is as follows:
- 0x00: global control.
- 0x08 and 0x0C: the count, low word and high word.
- 0x30: the per-core interrupt mask.
- 0x40 + 8·n: low word of the compare value for core n.
- 0x44 + 8·n: high word of the compare value for core n.

Masking a core's interrupt never affects the count.

Top module: `sysctr_top`

## Requirements
- R1: A write to bus offset 0x4 stores all 32 bits in the index register. A read of offset 0x4 returns those 32 bits. A read or write at offset 0x0 reaches the internal register whose address equals the full 32-bit index value.
- R2: After reset, the following values hold:
  - Global control reads 0x0000_0100 (disabled, divider field 3'b001).
  - The mask reads 0.
  - The count reads 0.
  - Every compare word reads 0xFFFF_FFFF.
  - Every core interrupt is low.
- R3: Global control bit 0 is the enable. While it is 1 the count advances. While it is 0 the count holds its value indefinitely.
- R4: Global control bits 10:8 select the divider, with bit 10 having the highest priority:
  - Bit 10 set: divide by 4.
  - Otherwise bit 9 set: divide by 2.
  - Otherwise: divide by 1.

  If the enable is held at 1 for exactly M clock cycles, starting from a disabled state, the count grows by floor(M/d).
- R5: A control write made while the enable is already 1 leaves the divider field unchanged. The enable bit of that same write still takes effect.
- R6: The mask register at index 0x30 holds one bit per core (NCORE bits). Bits at and above NCORE read as 0 and ignore writes. The mask value has no influence on counting.
- R7: Compare words at index 0x40 + 8·n (low) and 0x44 + 8·n (high) are writable and read back the written value.
- R8: Once the count is at least a core's compare value, that core's interrupt goes high one cycle later, provided its mask bit is 1. The interrupt stays high, even with counting disabled, until either word of that core's compare is written. Clearing the mask bit drops the interrupt at once.
- R9: A data read at index 0x08 returns the low count word and captures the high count word at the same instant. A data read at index 0x0C returns the captured high word.
- R10: A data read at any unmapped index returns 0. A data write there has no effect. The count indices 0x08 and 0x0C are read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte offset: 0x0 data window, 0x4 index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| core_irq | output | NCORE | Per-core level interrupt |

## Verification
The counting function is swept for enable windows of 1 to 9 cycles under each of the five divider codes. The codes are:
- the three one-hot settings;
- the two-bit code 3'b110, which tells priority decoding apart from a plain one-hot match;
- the empty code.

The floor(M/d) result for each window length separates an off-by-one start phase from an off-by-one stop phase.

The interrupt test gives every core a different compare distance and samples all interrupts on each cycle after enable. This separates the one-cycle latency from an immediate compare. One core is masked, then the mask is cleared and a compare word is rewritten, to distinguish mask gating from the sticky hit state. Lock-out of the divider while enabled and unmapped or read-only indices are probed through readback.

// File: rtl/sysctr_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, internal register indices and control field
// positions for the indexed system counter.
package sysctr_pkg;
    localparam int REG_W   = 32;
    localparam int CNT_W   = 64;
    localparam int DIV_W   = 3;
    localparam int DIV_LSB = 8;
    localparam int EN_BIT  = 0;

    localparam logic [REG_W-1:0] IX_CTRL     = 32'h0000_0000;
    localparam logic [REG_W-1:0] IX_CNT_LO   = 32'h0000_0008;
    localparam logic [REG_W-1:0] IX_CNT_HI   = 32'h0000_000C;
    localparam logic [REG_W-1:0] IX_MASK     = 32'h0000_0030;
    localparam logic [REG_W-1:0] IX_CMP_BASE = 32'h0000_0040;
    localparam logic [REG_W-1:0] CMP_STRIDE  = 32'h0000_0008;

    localparam logic [DIV_W-1:0] DIV_RESET = 3'b001;
endpackage

// File: rtl/sysctr_prescale.sv
`timescale 1ns/1ps
// Module: sysctr_prescale
// Turns the reference clock into count ticks. The divider code is decoded
// with priority: bit 2 gives /4, else bit 1 gives /2, else /1.
// Assumes the code only changes while en is low; the phase restarts at
// zero whenever en is low, so the first tick comes d cycles after enable.
module sysctr_prescale
    import sysctr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [1:0] phase_q;
    logic [1:0] last;

    // Purpose: map the divider code to the final phase value.
    always_comb begin
        if (div[2])      last = 2'd3;
        else if (div[1]) last = 2'd1;
        else             last = 2'd0;
    end

    assign tick = en && (phase_q == last);

    // Purpose: advance the phase while enabled, restart it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick) phase_q <= 2'd0;
        else                       phase_q <= phase_q + 2'd1;
    end

    // R4: at divide by 4 two ticks are never adjacent
    a_r4_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div[2]) |=> !tick);
endmodule

// File: rtl/sysctr_counter.sv
`timescale 1ns/1ps
// Module: sysctr_counter
// Holds the shared 64-bit count and the captured high word used for
// coherent two-word reads. Assumes tick is only high while en is high.
module sysctr_counter
    import sysctr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             rd_lo,
    output logic [CNT_W-1:0] cnt,
    output logic [REG_W-1:0] hi_latch
);
    // Purpose: increment the count on each prescaler tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= cnt + 1'b1;
    end

    // Purpose: capture the upper word when the lower word is read.
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_latch <= '0;
        else if (rd_lo) hi_latch <= cnt[CNT_W-1:REG_W];
    end

    // R3: disabled counting holds the value
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cnt));
    // R3: enabled counting moves by at most one per cycle
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));
    // R9: the captured word equals the upper count at the low read
    a_r9_coherent: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> hi_latch == $past(cnt[CNT_W-1:REG_W]));
endmodule

// File: rtl/sysctr_cmp.sv
`timescale 1ns/1ps
// Module: sysctr_cmp
// One core's compare slice: a sticky hit flag set one cycle after the
// count reaches the compare value, cleared by any write to that compare.
// The interrupt is the hit gated by the core's mask bit.
module sysctr_cmp
    import sysctr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic             cmp_wr,
    input  logic             mask_bit,
    output logic             irq
);
    logic hit_q;

    // Purpose: record that the count has reached the compare value.
    always_ff @(posedge clk) begin
        if (!rst_n)          hit_q <= 1'b0;
        else if (cmp_wr)     hit_q <= 1'b0;
        else if (cnt >= cmp) hit_q <= 1'b1;
    end

    assign irq = hit_q && mask_bit;

    // R8: a hit only rises after the count reached the compare value
    a_r8_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit_q) |-> $past(cnt) >= $past(cmp));
    // R8: a compare write removes the pending hit
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr |=> !hit_q);
endmodule

// File: rtl/sysctr_regs.sv
`timescale 1ns/1ps
// Module: sysctr_regs
// Index/data window and the internal register file: global control,
// interrupt mask and per-core compare words. Also forms the read mux.
// Assumes one access per cycle; bus_rdata is combinational on bus_rd.
module sysctr_regs
    import sysctr_pkg::*;
#(
    parameter int NCORE  = 4,
    parameter int ADDR_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [REG_W-1:0]       bus_wdata,
    input  logic [REG_W-1:0]       cnt_lo,
    input  logic [REG_W-1:0]       hi_latch,
    output logic [REG_W-1:0]       bus_rdata,
    output logic                   en,
    output logic [DIV_W-1:0]       div,
    output logic [NCORE-1:0]       mask,
    output logic [NCORE*CNT_W-1:0] cmp_flat,
    output logic [NCORE-1:0]       cmp_wr,
    output logic                   rd_cnt_lo
);
    localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_IDX  = ADDR_W'(4);

    logic [REG_W-1:0] idx_q;
    logic             wr_idx, wr_data, rd_data;
    logic             sel_ctrl, sel_lo, sel_hi, sel_mask;
    logic [NCORE-1:0] sel_cmp_lo, sel_cmp_hi;
    logic [CNT_W-1:0] cmp_q [NCORE];

    assign wr_idx   = bus_wr && (bus_addr == OFS_IDX);
    assign wr_data  = bus_wr && (bus_addr == OFS_DATA);
    assign rd_data  = bus_rd && (bus_addr == OFS_DATA);
    assign sel_ctrl = (idx_q == IX_CTRL);
    assign sel_lo   = (idx_q == IX_CNT_LO);
    assign sel_hi   = (idx_q == IX_CNT_HI);
    assign sel_mask = (idx_q == IX_MASK);
    assign rd_cnt_lo = rd_data && sel_lo;

    // Purpose: index register, control fields and mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            en    <= 1'b0;
            div   <= DIV_RESET;
            mask  <= '0;
        end else begin
            if (wr_idx) idx_q <= bus_wdata;
            if (wr_data && sel_ctrl) begin
                en <= bus_wdata[EN_BIT];
                if (!en) div <= bus_wdata[DIV_LSB +: DIV_W];
            end
            if (wr_data && sel_mask) mask <= bus_wdata[NCORE-1:0];
        end
    end

    for (genvar n = 0; n < NCORE; n++) begin : g_cmp
        localparam logic [REG_W-1:0] IX_LO = IX_CMP_BASE + REG_W'(n) * CMP_STRIDE;
        localparam logic [REG_W-1:0] IX_HI = IX_LO + REG_W'(4);

        assign sel_cmp_lo[n] = (idx_q == IX_LO);
        assign sel_cmp_hi[n] = (idx_q == IX_HI);
        assign cmp_wr[n]     = wr_data && (sel_cmp_lo[n] || sel_cmp_hi[n]);
        assign cmp_flat[n*CNT_W +: CNT_W] = cmp_q[n];

        // Purpose: hold this core's 64-bit compare value, word by word.
        always_ff @(posedge clk) begin
            if (!rst_n) cmp_q[n] <= '1;
            else if (wr_data && sel_cmp_lo[n]) cmp_q[n][REG_W-1:0] <= bus_wdata;
            else if (wr_data && sel_cmp_hi[n]) cmp_q[n][CNT_W-1:REG_W] <= bus_wdata;
        end
    end

    // Purpose: select read data from the index or the indexed register.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd && bus_addr == OFS_IDX) begin
            bus_rdata = idx_q;
        end else if (rd_data) begin
            if (sel_ctrl) begin
                bus_rdata[EN_BIT]              = en;
                bus_rdata[DIV_LSB +: DIV_W]    = div;
            end
            if (sel_lo)   bus_rdata = cnt_lo;
            if (sel_hi)   bus_rdata = hi_latch;
            if (sel_mask) bus_rdata[NCORE-1:0] = mask;
            for (int n = 0; n < NCORE; n++) begin
                if (sel_cmp_lo[n]) bus_rdata = cmp_q[n][REG_W-1:0];
                if (sel_cmp_hi[n]) bus_rdata = cmp_q[n][CNT_W-1:REG_W];
            end
        end
    end

    // R1: an index write is stored in full
    a_r1_idx: assert property (@(posedge clk) disable iff (!rst_n)
        wr_idx |=> idx_q == $past(bus_wdata));
    // R5: divider cannot move while counting is enabled
    a_r5_div_locked: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> $stable(div));
    // R7: at most one compare slice written per access
    a_r7_one_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmp_wr));
endmodule

// File: rtl/sysctr_top.sv
`timescale 1ns/1ps
// Module: sysctr_top
// Multi-core system counter reached through an index/data bus window.
// Joins the register file, prescaler, shared counter and one compare
// slice per core. Assumes a single clock and synchronous active-low reset.
module sysctr_top
    import sysctr_pkg::*;
#(
    parameter int NCORE  = 4,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NCORE-1:0]  core_irq
);
    logic                   en, tick, rd_cnt_lo;
    logic [DIV_W-1:0]       div;
    logic [NCORE-1:0]       mask, cmp_wr;
    logic [NCORE*CNT_W-1:0] cmp_flat;
    logic [CNT_W-1:0]       cnt;
    logic [REG_W-1:0]       hi_latch;

    sysctr_regs #(.NCORE(NCORE), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .cnt_lo(cnt[REG_W-1:0]), .hi_latch(hi_latch),
        .bus_rdata(bus_rdata), .en(en), .div(div), .mask(mask),
        .cmp_flat(cmp_flat), .cmp_wr(cmp_wr), .rd_cnt_lo(rd_cnt_lo)
    );

    sysctr_prescale u_pre (
        .clk(clk), .rst_n(rst_n), .en(en), .div(div), .tick(tick)
    );

    sysctr_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
        .rd_lo(rd_cnt_lo), .cnt(cnt), .hi_latch(hi_latch)
    );

    for (genvar n = 0; n < NCORE; n++) begin : g_core
        sysctr_cmp u_cmp (
            .clk(clk), .rst_n(rst_n), .cnt(cnt),
            .cmp(cmp_flat[n*CNT_W +: CNT_W]), .cmp_wr(cmp_wr[n]),
            .mask_bit(mask[n]), .irq(core_irq[n])
        );
    end

    // R6: a masked core never presents an interrupt
    a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (core_irq & ~mask) == '0);
endmodule

// File: tb/tb_sysctr_top.sv
`timescale 1ns/1ps
module tb_sysctr_top;
    localparam int NC = 4;
    localparam logic [2:0] DATA = 3'd0;
    localparam logic [2:0] IDX  = 3'd4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NC-1:0] core_irq;
    int errors = 0, checks = 0;

    always #2.5 clk = ~clk;

    sysctr_top #(.NCORE(NC), .ADDR_W(3)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .core_irq(core_irq)
    );

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wri(input logic [31:0] ix, input logic [31:0] d);
        wr(IDX, ix); wr(DATA, d);
    endtask

    task automatic rdi(input logic [31:0] ix, output logic [31:0] d);
        wr(IDX, ix); rd(DATA, d);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v, v0, v1, base;
        logic [31:0] codes [5];
        int divs [5];
        codes[0] = 32'h100; codes[1] = 32'h200; codes[2] = 32'h400;
        codes[3] = 32'h600; codes[4] = 32'h000;
        divs[0] = 1; divs[1] = 2; divs[2] = 4; divs[3] = 4; divs[4] = 1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        rdi(32'h0, v);  chk("R2 ctrl", v, 32'h100);
        rdi(32'h30, v); chk("R2 mask", v, 0);
        rdi(32'h08, v); chk("R2 cnt lo", v, 0);
        rdi(32'h0C, v); chk("R2 cnt hi", v, 0);
        for (int n = 0; n < NC; n++) begin
            rdi(32'h40 + 8*n, v); chk("R2 cmp lo", v, 32'hFFFF_FFFF);
            rdi(32'h44 + 8*n, v); chk("R2 cmp hi", v, 32'hFFFF_FFFF);
        end
        chk("R2 irq", core_irq, 0);

        // R1 index readback, R10 unmapped full-width index
        wr(IDX, 32'hDEAD_0030); rd(IDX, v); chk("R1 index readback", v, 32'hDEAD_0030);
        rd(DATA, v); chk("R10 unmapped wide index", v, 0);
        wr(DATA, 32'hF);
        rdi(32'h30, v); chk("R10 mask untouched by wide index", v, 0);

        // R6 upper mask bits
        wri(32'h30, 32'hFFFF_FFFF); rdi(32'h30, v); chk("R6 mask width", v, 32'hF);
        wri(32'h30, 32'h0);

        // R4 divider sweep; first two codes run with mask 0 (R6)
        for (int i = 0; i < 5; i++) begin
            if (i == 2) wri(32'h30, 32'hF);
            for (int m = 1; m <= 9; m++) begin
                wri(32'h0, codes[i]);
                rdi(32'h08, v0);
                wri(32'h0, codes[i] | 32'h1);
                idle(m - 1);
                wr(DATA, codes[i]);
                rdi(32'h08, v1);
                chk(i < 2 ? "R4/R6 count delta" : "R4 count delta", v1 - v0, 32'(m / divs[i]));
            end
        end

        // R3 hold while disabled, advance while enabled
        wri(32'h0, 32'h100);
        rdi(32'h08, v0); idle(10); rdi(32'h08, v1);
        chk("R3 hold", v1, v0);
        wri(32'h0, 32'h101); idle(9); wr(DATA, 32'h100);
        rdi(32'h08, v1);
        chk("R3 advance", v1 - v0, 10);

        // R9 high word read after low read
        rdi(32'h0C, v); chk("R9 hi word", v, 0);

        // R10 read-only counter and unmapped indices
        rdi(32'h08, v0);
        wri(32'h08, 32'h1234); wri(32'h0C, 32'h55);
        rdi(32'h08, v); chk("R10 cnt lo read-only", v, v0);
        rdi(32'h0C, v); chk("R10 cnt hi read-only", v, 0);
        wri(32'h60, 32'h5); rdi(32'h60, v); chk("R10 past last core", v, 0);
        rdi(32'h20, v); chk("R10 gap index", v, 0);

        // R7 and R8 compare and interrupts
        rdi(32'h08, base);
        for (int n = 0; n < NC; n++) begin
            wri(32'h40 + 8*n, base + 32'(3 + 2*n));
            wri(32'h44 + 8*n, 32'h0);
        end
        for (int n = 0; n < NC; n++) begin
            rdi(32'h40 + 8*n, v); chk("R7 cmp lo", v, base + 32'(3 + 2*n));
            rdi(32'h44 + 8*n, v); chk("R7 cmp hi", v, 0);
        end
        wri(32'h30, 32'hB);
        chk("R8 idle irq", core_irq, 0);
        wri(32'h0, 32'h101);
        for (int t = 1; t <= 16; t++) begin
            idle(1);
            for (int n = 0; n < NC; n++)
                chk("R8 irq timing", core_irq[n], (n != 2) && (t >= 3 + 2*n + 1));
        end
        wr(DATA, 32'h100);
        idle(3);
        chk("R8 level while disabled", core_irq, 4'hB);
        wri(32'h30, 32'h9);
        chk("R8 mask drop", core_irq, 4'h9);
        wri(32'h44, 32'hFFFF_FFFF);
        chk("R8 rewrite clears", core_irq, 4'h8);

        // R5 divider locked while enabled
        wri(32'h0, 32'h101);
        wr(DATA, 32'h401);
        rd(DATA, v); chk("R5 locked while on", v, 32'h101);
        wr(DATA, 32'h400);
        rd(DATA, v); chk("R5 locked on disabling write", v, 32'h100);
        wr(DATA, 32'h400);
        rd(DATA, v); chk("R5 accepted while off", v, 32'h400);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule